// File: doc/BRIEF.md
# Two-Line Up/Down Counter with Preset

This block is a 4-bit synchronous counter whose direction is chosen by which of two separate count lines is pulsed. A rising edge on the up line adds one and a rising edge on the down line subtracts one. A parameter sets the count range to decade (0 to 9) or to plain 4-bit binary (0 to 15). A parallel preset loads any 4-bit value while the active-low load input is held low. An active-high clear zeroes the count and overrides every other input.

Both count lines are treated as asynchronous. Each passes through a two-flop synchroniser and then an edge detector on the single system clock. A detected rise takes effect only if the other line's synchronised level is high. Two active-low terminal outputs support cascading. The carry output is low while the count sits at its maximum and the up line is low. The borrow output is low while the count is zero and the down line is low. Each output can therefore feed the matching count line of the next stage directly.

The load and clear inputs are synchronous to the system clock and act at the next rising edge. The asynchronous active-low reset is applied at once and is released through a two-flop reset synchroniser.

Top module: `updn_counter`

## Requirements
- R1: After reset, q is 0 and both carry_n and borrow_n are high.
- R2: A rising edge on cnt_up while cnt_dn is high raises q by one step. The new value appears on the third rising clock edge after the edge on cnt_up.
- R3: A rising edge on cnt_dn while cnt_up is high lowers q by one step, with the same three-edge latency as R2.
- R4: A rising edge on either count line is ignored while the other line is low. When both lines rise in the same cycle, q holds.
- R5: While clear is low and load_n is low, q takes din at the next clock edge, whatever the count lines are doing.
- R6: While clear is high, q becomes 0 at the next clock edge, even when load_n is low.
- R7: Counting up from the maximum (9 for MODULUS=10, 15 for MODULUS=16) gives 0. Counting down from 0 gives the maximum.
- R8: carry_n is low exactly when q equals the maximum and the synchronised up line is low. Otherwise it is high.
- R9: borrow_n is low exactly when q is 0 and the synchronised down line is low. Otherwise it is high.
- R10: With MODULUS=10, a preset of 10 to 14 counts up to the next value and 15 counts up to 0. Counting down from 10 to 15 subtracts one, and borrow_n stays high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up | input | 1 | Up count line; its rising edge counts up |
| cnt_dn | input | 1 | Down count line; its rising edge counts down |
| load_n | input | 1 | Active-low synchronous preset enable |
| clear | input | 1 | Active-high synchronous clear |
| din | input | 4 | Preset value |
| q | output | 4 | Counter value |
| carry_n | output | 1 | Active-low overflow pulse for cascading |
| borrow_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
The assertions assume that load_n, clear and din are synchronous to the system clock. They also assume that the count lines change no more often than once every few cycles, so that every level reaches the synchroniser outputs. The stimulus drives every input on the falling clock edge. It holds each count-line level for at least two clock cycles before the opposite transition, and it only pulses a line while the other line is at its intended level. The sweep presets each of the 16 values and steps once in each direction. Two instances, one decade and one binary, share the same stimulus.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int CNT_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t step_up(cnt_t v, int modulus);
    cnt_t r;
    if (int'(v) == modulus - 1) r = '0;
    else                        r = v + cnt_t'(1);
    return r;
  endfunction

  function automatic cnt_t step_dn(cnt_t v, int modulus);
    cnt_t r;
    if (v == '0) r = cnt_t'(modulus - 1);
    else         r = v - cnt_t'(1);
    return r;
  endfunction

endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
    prev_d = sync_q[STAGES-1];
  end

  // idle level of a count line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load_n,
  input  cnt_t din,
  input  logic inc,
  input  logic dec,
  output cnt_t q
);

  cnt_t cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!load_n) begin
      cnt_d  = din;
      cnt_en = 1'b1;
    end else if (inc && !dec) begin
      cnt_d  = step_up(cnt_q, MODULUS);
      cnt_en = 1'b1;
    end else if (dec && !inc) begin
      cnt_d  = step_dn(cnt_q, MODULUS);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q = cnt_q;

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int MODULUS   = 10,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             load_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam int   LINES   = 2;
  localparam int   UP_IDX  = 0;
  localparam int   DN_IDX  = 1;
  localparam cnt_t CNT_MAX = cnt_t'(MODULUS - 1);

  logic             rst_int_n;
  logic [LINES-1:0] line_raw, line_lvl, line_rise;
  logic             inc, dec;
  cnt_t             cnt;

  updn_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign line_raw[UP_IDX] = cnt_up;
  assign line_raw[DN_IDX] = cnt_dn;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    updn_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .line_i  (line_raw[g]),
      .level_o (line_lvl[g]),
      .rise_o  (line_rise[g])
    );
  end

  // a rise counts only while the opposite line is held high
  assign inc = line_rise[UP_IDX] & line_lvl[DN_IDX];
  assign dec = line_rise[DN_IDX] & line_lvl[UP_IDX];

  updn_core #(.MODULUS(MODULUS)) u_core (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear  (clear),
    .load_n (load_n),
    .din    (din),
    .inc    (inc),
    .dec    (dec),
    .q      (cnt)
  );

  assign q        = cnt;
  assign carry_n  = ~((cnt == CNT_MAX) & ~line_lvl[UP_IDX]);
  assign borrow_n = ~((cnt == '0)      & ~line_lvl[DN_IDX]);

endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk
  import updn_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             load_n,
  input logic             clear,
  input logic [CNT_W-1:0] din,
  input logic [CNT_W-1:0] q,
  input logic             carry_n,
  input logic             borrow_n
);

  localparam cnt_t CNT_MAX = cnt_t'(MODULUS - 1);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clear && load_n) |=> (q == $past(q) ||
                            q == step_up($past(q), MODULUS) ||
                            q == step_dn($past(q), MODULUS)));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clear && !load_n) |=> (q == $past(din)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    clear |=> (q == '0));

  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !carry_n |-> (q == CNT_MAX));

  p_borrow_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !borrow_n |-> (q == '0));

endmodule

bind updn_counter updn_counter_chk #(.MODULUS(MODULUS)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .load_n    (load_n),
  .clear     (clear),
  .din       (din),
  .q         (q),
  .carry_n   (carry_n),
  .borrow_n  (borrow_n)
);

// File: tb/updn_counter_tb.sv
module updn_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n, cnt_up, cnt_dn, load_n, clear;
  logic [3:0] din;
  logic [3:0] q_dec, q_bin;
  logic       cy_dec, cy_bin, bw_dec, bw_bin;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  updn_counter #(.MODULUS(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .load_n(load_n), .clear(clear), .din(din),
    .q(q_dec), .carry_n(cy_dec), .borrow_n(bw_dec));

  updn_counter #(.MODULUS(16)) u_bin (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .load_n(load_n), .clear(clear), .din(din),
    .q(q_bin), .carry_n(cy_bin), .borrow_n(bw_bin));

  function automatic int e_up(int v, int m);
    return (v == m - 1) ? 0 : (v + 1) % 16;
  endfunction

  function automatic int e_dn(int v, int m);
    return (v == 0) ? m - 1 : v - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic preset(int v);
    din = 4'(v); load_n = 1'b0;
    tick(1);
    load_n = 1'b1;
    chk("R5 load dec", q_dec, v);
    chk("R5 load bin", q_bin, v);
  endtask

  // up pulse: low phase checks carry, then rise and count
  task automatic pulse_up(string tag);
    int vd, vb;
    vd = q_dec; vb = q_bin;
    cnt_up = 1'b0; tick(2);
    chk("R8 carry dec", cy_dec, (vd == 9)  ? 0 : 1);
    chk("R8 carry bin", cy_bin, (vb == 15) ? 0 : 1);
    cnt_up = 1'b1; tick(2);
    chk("R2 latency dec", q_dec, vd);
    tick(1);
    chk({tag, " up dec"}, q_dec, e_up(vd, 10));
    chk({tag, " up bin"}, q_bin, e_up(vb, 16));
    chk("R8 carry idle", cy_dec, 1);
  endtask

  task automatic pulse_dn(string tag);
    int vd, vb;
    vd = q_dec; vb = q_bin;
    cnt_dn = 1'b0; tick(2);
    chk("R9 borrow dec", bw_dec, (vd == 0) ? 0 : 1);
    chk("R9 borrow bin", bw_bin, (vb == 0) ? 0 : 1);
    cnt_dn = 1'b1; tick(3);
    chk({tag, " dn dec"}, q_dec, e_dn(vd, 10));
    chk({tag, " dn bin"}, q_bin, e_dn(vb, 16));
    chk("R9 borrow idle", bw_dec, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_up = 1'b1; cnt_dn = 1'b1;
    load_n = 1'b1; clear = 1'b0; din = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R1 q", q_dec, 0);
    chk("R1 carry_n", cy_dec, 1);
    chk("R1 borrow_n", bw_dec, 1);

    // sweep every preset value one step each way
    for (int v = 0; v < 16; v++) begin
      preset(v);
      pulse_up((v >= 10) ? "R10" : (v == 9 || v == 15) ? "R7" : "R2");
      preset(v);
      pulse_dn((v >= 10) ? "R10" : (v == 0) ? "R7" : "R3");
    end

    // R4: up rise while down held low is ignored, then down rise counts
    preset(5);
    cnt_dn = 1'b0; tick(2);
    cnt_up = 1'b0; tick(2);
    cnt_up = 1'b1; tick(4);
    chk("R4 ignored up", q_dec, 5);
    cnt_dn = 1'b1; tick(3);
    chk("R3 after release", q_dec, 4);

    // R4: simultaneous rises hold
    cnt_up = 1'b0; cnt_dn = 1'b0; tick(3);
    cnt_up = 1'b1; cnt_dn = 1'b1; tick(4);
    chk("R4 both rise dec", q_dec, 4);
    chk("R4 both rise bin", q_bin, 4);

    // R5: load wins over a count landing in the same cycle
    cnt_up = 1'b0; tick(2);
    cnt_up = 1'b1; tick(2);
    din = 4'd3; load_n = 1'b0; tick(1);
    load_n = 1'b1;
    chk("R5 load over count", q_dec, 3);
    tick(2);
    chk("R5 no late count", q_dec, 3);

    // R6: clear over load, and clear alone
    din = 4'd6; load_n = 1'b0; clear = 1'b1; tick(1);
    load_n = 1'b1; clear = 1'b0;
    chk("R6 clear over load", q_dec, 0);
    preset(8);
    clear = 1'b1; tick(1);
    clear = 1'b0;
    chk("R6 clear", q_bin, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule